// File: doc/BRIEF.md
# Lock-Free Set/Clear GPIO Bank

This block is one bank of general-purpose pins behind a single 32-bit register. Software never reads, modifies and writes that register back. Each write carries one-hot command bits, and each bit names a single action on a single pin. Any bit written as 0 changes nothing. Because of this, several software agents can touch different pins of the same bank at the same moment without any lock.

Every pin owns two command pairs. The lower pair sits at bits 2n and 2n+1 and sets the level the pin drives. The upper pair sits at bits 2n+16 and 2n+17 and sets whether the pin drives or listens. A read of the register shows each pin's synchronized pad level in its odd bit 2n+1.

The pin count is a parameter. A chip instantiates one copy per bank, for example an 8-pin bank and a 4-pin bank, each at its own address. The pad interface is always eight lanes wide, and lanes above the pin count stay quiet.

Top module: `gpio_setclr_bank`

## Requirements
- R1: After reset every pin is an input (pad_oe all 0), every stored output level is 0 (pad_out all 0), and read data is 0 while the pads are low.
- R2: A write with bit 2n at 1 sets pin n's pad_out to 0 after the next rising clock edge. A write with bit 2n+1 at 1 sets it to 1 after that edge.
- R3: A write with bit 2n+16 at 1 makes pin n an output (pad_oe[n]=1). A write with bit 2n+17 at 1 makes it an input (pad_oe[n]=0).
- R4: Command bits written as 0 leave their pin's level and direction unchanged, and a cycle with wr_en low changes nothing.
- R5: If both bits of a pair are 1 in one write, the high level (bit 2n+1) and output mode (bit 2n+16) win.
- R6: A single write that carries both a level command and the output-mode command for a pin updates pad_out and pad_oe at the same clock edge, so the pin never drives an earlier level.
- R7: An input-mode pin keeps its stored level and still accepts level commands. A later switch to output drives the most recently written level.
- R8: pad_in[n] passes through two flip-flops before it reaches read bit 2n+1. A change becomes visible after the second rising edge and not after the first.
- R9: Read bits at even positions and bits 16 to 31 are always 0.
- R10: With PIN_COUNT below 8, command bits for pins PIN_COUNT to 7 are ignored. Those lanes keep pad_out and pad_oe at 0, and their read bits return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the bank register |
| wr_data | input | 32 | One-hot command bits (level pair at 2n/2n+1, direction pair at 2n+16/2n+17) |
| rd_data | output | 32 | Synchronized pad levels in bit 2n+1, all other bits 0 |
| pad_in | input | 8 | Level seen at each pad |
| pad_out | output | 8 | Level each pin drives when enabled |
| pad_oe | output | 8 | Output enable per pin, 1 means drive |

## Verification
The bench first drives single-pin level and direction commands, which tells the low bit of a pair apart from the high bit. It then sends multi-pin words, all-zero words and strobe-less words, which shows whether one pin's write disturbs another pin's state. Words with both bits of a pair set expose the priority rule. A word that carries a level command and the output-mode command together shows whether the two take effect at the same edge. Pad patterns are sampled one edge and two edges after a change to separate the second synchronizer stage from the first, and a 4-pin instance receives all-ones words to show that out-of-range lanes are masked.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;

    localparam int BANK_MAX = 8;
    localparam int REG_W    = 32;
    localparam int DIR_BASE = 16;

    typedef logic [BANK_MAX-1:0] pin_vec_t;

    // Per-pin commands decoded from one register write.
    typedef struct packed {
        pin_vec_t drive_low;
        pin_vec_t drive_high;
        pin_vec_t make_out;
        pin_vec_t make_in;
    } pin_cmd_t;

    // Stored pin state.
    typedef struct packed {
        pin_vec_t level;
        pin_vec_t oe;
    } pin_state_t;

    // Two-stage input synchronizer.
    typedef struct packed {
        pin_vec_t meta;
        pin_vec_t stable;
    } sync_state_t;

    // Lanes that exist in a bank of 'count' pins.
    function automatic pin_vec_t lane_mask(input int count);
        pin_vec_t m;
        m = '0;
        for (int i = 0; i < BANK_MAX; i++) begin
            if (i < count) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/gpio_sc_decode.sv
module gpio_sc_decode
    import gpio_sc_pkg::*;
#(
    parameter int PIN_COUNT = 8
) (
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output pin_cmd_t         cmd
);

    localparam pin_vec_t LANES = lane_mask(PIN_COUNT);

    pin_cmd_t raw;

    // Each lane pulls its own pairs out of the interleaved word.
    for (genvar n = 0; n < BANK_MAX; n++) begin : g_lane
        assign raw.drive_low[n]  = wr_data[2*n];
        assign raw.drive_high[n] = wr_data[2*n+1];
        assign raw.make_out[n]   = wr_data[2*n+DIR_BASE];
        assign raw.make_in[n]    = wr_data[2*n+DIR_BASE+1];
    end

    // Qualify with the strobe and drop lanes the bank does not have.
    always_comb begin
        cmd.drive_low  = raw.drive_low  & LANES & {BANK_MAX{wr_en}};
        cmd.drive_high = raw.drive_high & LANES & {BANK_MAX{wr_en}};
        cmd.make_out   = raw.make_out   & LANES & {BANK_MAX{wr_en}};
        cmd.make_in    = raw.make_in    & LANES & {BANK_MAX{wr_en}};
    end

endmodule

// File: rtl/gpio_sc_state.sv
module gpio_sc_state
    import gpio_sc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  pin_cmd_t cmd,
    output pin_vec_t level,
    output pin_vec_t oe
);

    pin_state_t st_d, st_q;

    // Clearing first and then setting lets the high and output commands
    // override their partners when both bits of a pair are written.
    always_comb begin
        st_d       = st_q;
        st_d.level = (st_q.level & ~cmd.drive_low) | cmd.drive_high;
        st_d.oe    = (st_q.oe    & ~cmd.make_in)   | cmd.make_out;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.level;
    assign oe    = st_q.oe;

endmodule

// File: rtl/gpio_sc_sync.sv
module gpio_sc_sync
    import gpio_sc_pkg::*;
#(
    parameter int PIN_COUNT = 8
) (
    input  logic     clk,
    input  logic     rst_n,
    input  pin_vec_t pad_in,
    output pin_vec_t synced
);

    localparam pin_vec_t LANES = lane_mask(PIN_COUNT);

    sync_state_t sy_d, sy_q;

    always_comb begin
        sy_d.meta   = pad_in & LANES;
        sy_d.stable = sy_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign synced = sy_q.stable;

endmodule

// File: rtl/gpio_sc_rdpack.sv
module gpio_sc_rdpack
    import gpio_sc_pkg::*;
(
    input  pin_vec_t         synced,
    output logic [REG_W-1:0] rd_data
);

    // Odd lanes of the low half carry the levels. Everything else reads 0.
    always_comb begin
        rd_data = '0;
        for (int n = 0; n < BANK_MAX; n++) begin
            rd_data[2*n+1] = synced[n];
        end
    end

endmodule

// File: rtl/gpio_setclr_bank.sv
module gpio_setclr_bank
    import gpio_sc_pkg::*;
#(
    parameter int PIN_COUNT = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    input  logic [7:0]  pad_in,
    output logic [7:0]  pad_out,
    output logic [7:0]  pad_oe
);

    pin_cmd_t cmd;
    pin_vec_t synced;

    gpio_sc_decode #(.PIN_COUNT(PIN_COUNT)) u_decode (
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cmd     (cmd)
    );

    gpio_sc_state u_state (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd   (cmd),
        .level (pad_out),
        .oe    (pad_oe)
    );

    gpio_sc_sync #(.PIN_COUNT(PIN_COUNT)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_in (pad_in),
        .synced (synced)
    );

    gpio_sc_rdpack u_rdpack (
        .synced  (synced),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/gpio_sc_checker.sv
module gpio_sc_checker #(
    parameter int PIN_COUNT = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic [31:0] rd_data,
    input logic [7:0]  pad_in,
    input logic [7:0]  pad_out,
    input logic [7:0]  pad_oe
);

    localparam logic [31:0] ODD_LOW = 32'h0000_AAAA;

    logic [1:0] since_rst;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R4: no strobe, no change of pin state
    p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(pad_out) && $stable(pad_oe)));

    // R9: unused read bits stay 0
    p_rd_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~ODD_LOW) == 32'h0);

    for (genvar n = 0; n < 8; n++) begin : g_pin
        if (n < PIN_COUNT) begin : g_live
            // R2 and R5: high command (wins over low)
            p_level_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_data[2*n+1]) |=> pad_out[n]);
            // R2: low command alone
            p_level_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_data[2*n] && !wr_data[2*n+1]) |=> !pad_out[n]);
            // R3 and R5: output command (wins over input)
            p_dir_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_data[2*n+16]) |=> pad_oe[n]);
            // R3: input command alone
            p_dir_in_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_data[2*n+17] && !wr_data[2*n+16]) |=> !pad_oe[n]);
            // R8: two-stage latency from pad to read bit
            p_sync_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (since_rst >= 2'd2) |-> (rd_data[2*n+1] == $past(pad_in[n], 2)));
        end else begin : g_dead
            // R10: absent lanes ignore commands and read 0
            p_dead_lane_r10: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && (|{wr_data[2*n+17:2*n+16], wr_data[2*n+1:2*n]}))
                |=> (!pad_out[n] && !pad_oe[n]));
            p_dead_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
                ((since_rst >= 2'd2) && $past(pad_in[n], 2)) |-> !rd_data[2*n+1]);
        end
    end

endmodule

bind gpio_setclr_bank gpio_sc_checker #(.PIN_COUNT(PIN_COUNT)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .pad_in  (pad_in),
    .pad_out (pad_out),
    .pad_oe  (pad_oe)
);

// File: tb/gpio_setclr_bank_test.sv
module gpio_setclr_bank_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en8 = 1'b0, wr_en4 = 1'b0;
    logic [31:0] wr_data8 = '0, wr_data4 = '0;
    logic [31:0] rd_data8, rd_data4;
    logic [7:0]  pad_in8 = '0, pad_in4 = '0;
    logic [7:0]  pad_out8, pad_oe8, pad_out4, pad_oe4;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    gpio_setclr_bank #(.PIN_COUNT(8)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en8), .wr_data(wr_data8),
        .rd_data(rd_data8), .pad_in(pad_in8), .pad_out(pad_out8), .pad_oe(pad_oe8)
    );

    gpio_setclr_bank #(.PIN_COUNT(4)) uut4 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en4), .wr_data(wr_data4),
        .rd_data(rd_data4), .pad_in(pad_in4), .pad_out(pad_out4), .pad_oe(pad_oe4)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Present a word for one rising edge; returns at the following falling edge.
    task automatic wr8(input logic en, input logic [31:0] d);
        @(negedge clk); wr_en8 = en; wr_data8 = d;
        @(negedge clk); wr_en8 = 1'b0; wr_data8 = '0;
    endtask

    task automatic wr4(input logic [31:0] d);
        @(negedge clk); wr_en4 = 1'b1; wr_data4 = d;
        @(negedge clk); wr_en4 = 1'b0; wr_data4 = '0;
    endtask

    task automatic t_reset;
        check("R1 pad_out", {24'h0, pad_out8}, 32'h0);
        check("R1 pad_oe",  {24'h0, pad_oe8},  32'h0);
        check("R1 rd_data", rd_data8, 32'h0);
    endtask

    task automatic t_level;
        wr8(1'b1, 32'h0000_0082);              // pin0 high, pin3 high
        check("R2 high", {24'h0, pad_out8}, 32'h09);
        wr8(1'b1, 32'h0000_0001);              // pin0 low
        check("R2 low", {24'h0, pad_out8}, 32'h08);
    endtask

    task automatic t_dir;
        wr8(1'b1, (32'h1 << 16) | (32'h1 << 22));
        check("R3 out", {24'h0, pad_oe8}, 32'h09);
        wr8(1'b1, 32'h1 << 23);
        check("R3 in", {24'h0, pad_oe8}, 32'h01);
    endtask

    task automatic t_untouched;
        wr8(1'b1, 32'h0);
        check("R4 zero word out", {24'h0, pad_out8}, 32'h08);
        check("R4 zero word oe",  {24'h0, pad_oe8},  32'h01);
        wr8(1'b0, 32'hFFFF_FFFF);
        check("R4 no strobe out", {24'h0, pad_out8}, 32'h08);
        check("R4 no strobe oe",  {24'h0, pad_oe8},  32'h01);
    endtask

    task automatic t_priority;
        wr8(1'b1, 32'h0000_0030);              // pin2 low and high
        check("R5 level pair", {24'h0, pad_out8}, 32'h0C);
        wr8(1'b1, (32'h1 << 20) | (32'h1 << 21));
        check("R5 dir pair", {24'h0, pad_oe8}, 32'h05);
    endtask

    task automatic t_same_edge;
        wr8(1'b1, (32'h1 << 11) | (32'h1 << 26));  // pin5 high + output
        check("R6 level", {24'h0, pad_out8}, 32'h2C);
        check("R6 oe",    {24'h0, pad_oe8},  32'h25);
    endtask

    task automatic t_hold;
        wr8(1'b1, 32'h1 << 27);                // pin5 to input
        check("R7 oe off", {24'h0, pad_oe8},  32'h05);
        check("R7 kept",   {24'h0, pad_out8}, 32'h2C);
        wr8(1'b1, 32'h1 << 10);                // pin5 low while input
        check("R7 level in input", {24'h0, pad_out8}, 32'h0C);
        wr8(1'b1, 32'h1 << 26);                // pin5 back to output
        check("R7 re-enable oe",  {24'h0, pad_oe8},  32'h25);
        check("R7 re-enable out", {24'h0, pad_out8}, 32'h0C);
    endtask

    task automatic t_sync;
        @(negedge clk); pad_in8 = 8'hA5;
        @(negedge clk);
        check("R8 one edge", rd_data8, 32'h0);
        @(negedge clk);
        check("R8 two edges", rd_data8, 32'h0000_8822);
        pad_in8 = 8'hFF;
        @(negedge clk); @(negedge clk);
        check("R9 all high", rd_data8, 32'h0000_AAAA);
        check("R9 zero bits", rd_data8 & 32'hFFFF_5555, 32'h0);
    endtask

    task automatic t_narrow;
        wr4(32'hFFFF_FFFF);
        check("R10 out", {24'h0, pad_out4}, 32'h0F);
        check("R10 oe",  {24'h0, pad_oe4},  32'h0F);
        wr4(32'h0000_2001);                    // pin0 low, pin6 high
        check("R10 ignore pin6", {24'h0, pad_out4}, 32'h0E);
        @(negedge clk); pad_in4 = 8'hFF;
        @(negedge clk); @(negedge clk);
        check("R10 read", rd_data4, 32'h0000_00AA);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_level();
        t_dir();
        t_untouched();
        t_priority();
        t_same_edge();
        t_hold();
        t_sync();
        t_narrow();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule